// File: doc/BRIEF.md
# DMA Job Descriptor Checker

This block sits in front of a DMA transfer engine and vets a job descriptor at the moment software asks for a start. On a go request it captures the descriptor fields: both addresses, the packed pair of address-space IDs, the transfer-width code, the total and chunk byte counts, the opcode, and the enabled memory window (base, limit, valid flag). In the next cycle it classifies the captured descriptor against a set of independent rules.

Each broken rule raises its own bit in an 8-bit error vector. A clean descriptor produces a one-cycle start pulse for the engine. Any failed rule produces a one-cycle error interrupt request instead, and the engine does not start. Error bits are sticky. They accumulate across jobs until software clears them with a write-one-to-clear strobe.

The block does not move data, compute hashes or drive a bus. Bit 4 of the vector is kept for bus faults, which a checker cannot observe, so it always reads 0 here.

Top module: `dma_cfg_checker`

## Requirements
- R1: When go is high at clock edge N, exactly one of start_o (no rule broken) or err_irq_o (a rule broken) is high for the single cycle after edge N+1. The two are never high together, and neither rises without a go.
- R2: space_id_i carries the source ID in bits 3:0 and the destination ID in bits 7:4. The legal codes are 0x7 (internal bus), 0xA (control bus) and 0x9 (system bus). Any other code in either field sets error bit 7.
- R3: Width code 0 selects 1 byte, code 1 selects 2 bytes and code 2 selects 4 bytes. Code 3 sets error bit 3.
- R4: A total size of zero, or a chunk size of zero, sets error bit 3.
- R5: Opcodes 1, 2 and 3 are hashing operations. A hashing opcode with a width code other than 2 sets error bit 3. Opcode 0 (copy) is accepted at every valid width.
- R6: An opcode greater than 3 sets error bit 2.
- R7: A source address that is not a multiple of the transfer width sets bit 0. A destination address that is not a multiple of the transfer width sets bit 1. Width code 3 has no alignment rule.
- R8: If address bits 1:0 of the source and destination differ, bit 0 is set.
- R9: If either ID field selects the internal bus (0x7) while the range-valid flag is 0, bit 6 is set.
- R10: If the range-valid flag is 1 and base is greater than limit, bit 5 is set.
- R11: Suppose the range-valid flag is 1 and base is no greater than limit. Then a side that selects the internal bus and whose address lies outside the inclusive window from base to limit sets its own address bit: bit 0 for the source, bit 1 for the destination.
- R12: Error bits are sticky and OR-accumulate over evaluations. A high err_clear_i clears them all. If a clear and an evaluation fall in the same cycle, only the new bits remain. Bit 4 is always 0.
- R13: After reset, all outputs are 0. Descriptor inputs that change while go is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start request; captures the descriptor |
| err_clear_i | input | 1 | Software write-one-to-clear of all error bits |
| src_addr_i | input | ADDR_W | Source address |
| dst_addr_i | input | ADDR_W | Destination address |
| space_id_i | input | 8 | Destination ID in bits 7:4, source ID in bits 3:0 |
| width_code_i | input | 2 | Transfer-width code |
| total_size_i | input | SIZE_W | Total byte count |
| chunk_size_i | input | SIZE_W | Chunk byte count |
| opcode_i | input | OPC_W | Operation code |
| range_base_i | input | ADDR_W | Enabled window base (inclusive) |
| range_limit_i | input | ADDR_W | Enabled window limit (inclusive) |
| range_valid_i | input | 1 | Enabled window has been programmed |
| err_code_o | output | 8 | Sticky error vector |
| start_o | output | 1 | One-cycle pulse that lets the engine start |
| err_irq_o | output | 1 | One-cycle error interrupt request |

## Verification
The bench builds the checker with ADDR_W=16 and SIZE_W=8. With these values, window bounds, addresses just past the limit and the zero-size case all fit in short literals that can be checked by hand. An 8-bit size field also keeps the total and chunk fields independent in every rule. A behavioural model recomputes every rule from integer arithmetic and is compared against all outputs on every clock. Directed jobs then target each rule's boundary: inclusive window edges, sub-word alignment at each width, hashing at a narrow width, and a clear that coincides with a fresh evaluation.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int ERR_W    = 8;
   localparam int SPACE_W  = 4;
   localparam int WCODE_W  = 2;

   // error vector bit positions (decoded by software)
   localparam int EB_SRC   = 0;
   localparam int EB_DST   = 1;
   localparam int EB_OPC   = 2;
   localparam int EB_SIZE  = 3;
   localparam int EB_BUS   = 4;
   localparam int EB_WIN   = 5;
   localparam int EB_NOWIN = 6;
   localparam int EB_SPACE = 7;

   localparam logic [SPACE_W-1:0] SPACE_INTERNAL = 4'h7;
   localparam logic [SPACE_W-1:0] SPACE_CTRL     = 4'hA;
   localparam logic [SPACE_W-1:0] SPACE_SYSTEM   = 4'h9;

   typedef enum logic [WCODE_W-1:0] {
      WID_1B  = 2'd0,
      WID_2B  = 2'd1,
      WID_4B  = 2'd2,
      WID_BAD = 2'd3
   } width_code_e;

   typedef logic [ERR_W-1:0] err_vec_t;

   function automatic logic space_is_legal(input logic [SPACE_W-1:0] id);
      return (id == SPACE_INTERNAL) || (id == SPACE_CTRL) || (id == SPACE_SYSTEM);
   endfunction

   function automatic logic [1:0] low_mask(input logic [WCODE_W-1:0] code);
      case (code)
         WID_2B:  return 2'b01;
         WID_4B:  return 2'b11;
         default: return 2'b00;
      endcase
   endfunction
endpackage

// File: rtl/dcc_snapshot.sv
module dcc_snapshot #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 32,
   parameter int OPC_W  = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 go_i,
   input  logic [ADDR_W-1:0]    src_addr_i,
   input  logic [ADDR_W-1:0]    dst_addr_i,
   input  logic [7:0]           space_id_i,
   input  logic [1:0]           width_code_i,
   input  logic [SIZE_W-1:0]    total_size_i,
   input  logic [SIZE_W-1:0]    chunk_size_i,
   input  logic [OPC_W-1:0]     opcode_i,
   input  logic [ADDR_W-1:0]    range_base_i,
   input  logic [ADDR_W-1:0]    range_limit_i,
   input  logic                 range_valid_i,
   output logic                 eval_o,
   output logic [ADDR_W-1:0]    src_addr_o,
   output logic [ADDR_W-1:0]    dst_addr_o,
   output logic [7:0]           space_id_o,
   output logic [1:0]           width_code_o,
   output logic [SIZE_W-1:0]    total_size_o,
   output logic [SIZE_W-1:0]    chunk_size_o,
   output logic [OPC_W-1:0]     opcode_o,
   output logic [ADDR_W-1:0]    range_base_o,
   output logic [ADDR_W-1:0]    range_limit_o,
   output logic                 range_valid_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         eval_o        <= 1'b0;
         src_addr_o    <= '0;
         dst_addr_o    <= '0;
         space_id_o    <= 8'h77;
         width_code_o  <= 2'd2;
         total_size_o  <= '0;
         chunk_size_o  <= '0;
         opcode_o      <= '0;
         range_base_o  <= '0;
         range_limit_o <= '0;
         range_valid_o <= 1'b0;
      end else begin
         eval_o <= go_i;
         if (go_i) begin
            src_addr_o    <= src_addr_i;
            dst_addr_o    <= dst_addr_i;
            space_id_o    <= space_id_i;
            width_code_o  <= width_code_i;
            total_size_o  <= total_size_i;
            chunk_size_o  <= chunk_size_i;
            opcode_o      <= opcode_i;
            range_base_o  <= range_base_i;
            range_limit_o <= range_limit_i;
            range_valid_o <= range_valid_i;
         end
      end
   end
endmodule

// File: rtl/dcc_side_check.sv
module dcc_side_check
   import dcc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [SPACE_W-1:0] space_i,
   input  logic [1:0]         mask_i,
   input  logic               win_ok_i,
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [ADDR_W-1:0]  limit_i,
   output logic               misalign_o,
   output logic               outside_o,
   output logic               internal_o,
   output logic               illegal_o
);
   always_comb begin
      internal_o = (space_i == SPACE_INTERNAL);
      illegal_o  = !space_is_legal(space_i);
      misalign_o = |(addr_i[1:0] & mask_i);
      outside_o  = internal_o && win_ok_i && ((addr_i < base_i) || (addr_i > limit_i));
   end
endmodule

// File: rtl/dcc_rules.sv
module dcc_rules
   import dcc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 32,
   parameter int OPC_W  = 4
) (
   input  logic [ADDR_W-1:0]  src_addr_i,
   input  logic [ADDR_W-1:0]  dst_addr_i,
   input  logic [7:0]         space_id_i,
   input  logic [1:0]         width_code_i,
   input  logic [SIZE_W-1:0]  total_size_i,
   input  logic [SIZE_W-1:0]  chunk_size_i,
   input  logic [OPC_W-1:0]   opcode_i,
   input  logic [ADDR_W-1:0]  range_base_i,
   input  logic [ADDR_W-1:0]  range_limit_i,
   input  logic               range_valid_i,
   output err_vec_t           err_o
);
   localparam int SIDES = 2;
   localparam logic [OPC_W-1:0] OPC_LAST = OPC_W'(3);

   logic [SIDES-1:0][ADDR_W-1:0]  side_addr;
   logic [SIDES-1:0][SPACE_W-1:0] side_space;
   logic [SIDES-1:0]              misalign, outside, internal, illegal;
   logic [1:0]                    mask;
   logic                          win_ok, win_inverted;
   logic                          width_bad, size_zero, hashing, hash_narrow, opc_bad;

   assign side_addr[0]  = src_addr_i;
   assign side_addr[1]  = dst_addr_i;
   assign side_space[0] = space_id_i[3:0];
   assign side_space[1] = space_id_i[7:4];

   assign mask         = low_mask(width_code_i);
   assign win_inverted = range_valid_i && (range_base_i > range_limit_i);
   assign win_ok       = range_valid_i && !win_inverted;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      dcc_side_check #(.ADDR_W(ADDR_W)) side_i (
         .addr_i     (side_addr[s]),
         .space_i    (side_space[s]),
         .mask_i     (mask),
         .win_ok_i   (win_ok),
         .base_i     (range_base_i),
         .limit_i    (range_limit_i),
         .misalign_o (misalign[s]),
         .outside_o  (outside[s]),
         .internal_o (internal[s]),
         .illegal_o  (illegal[s])
      );
   end

   assign width_bad   = (width_code_i == WID_BAD);
   assign size_zero   = (total_size_i == '0) || (chunk_size_i == '0);
   assign hashing     = (opcode_i != '0) && (opcode_i <= OPC_LAST);
   assign hash_narrow = hashing && (width_code_i != WID_4B);
   assign opc_bad     = (opcode_i > OPC_LAST);

   always_comb begin
      err_o           = '0;
      err_o[EB_SRC]   = misalign[0] || outside[0] || (src_addr_i[1:0] != dst_addr_i[1:0]);
      err_o[EB_DST]   = misalign[1] || outside[1];
      err_o[EB_OPC]   = opc_bad;
      err_o[EB_SIZE]  = width_bad || size_zero || hash_narrow;
      err_o[EB_BUS]   = 1'b0;
      err_o[EB_WIN]   = win_inverted;
      err_o[EB_NOWIN] = (|internal) && !range_valid_i;
      err_o[EB_SPACE] = |illegal;
   end

   always_comb begin
      assert (!(err_o[EB_WIN] && (outside != '0)))  // R11
         else $error("AST_WINDOW_EXCLUSIVE");
   end
endmodule

// File: rtl/dcc_report.sv
module dcc_report
   import dcc_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     eval_i,
   input  err_vec_t found_i,
   input  logic     clear_i,
   output err_vec_t code_o,
   output logic     start_o,
   output logic     err_irq_o
);
   err_vec_t fresh;
   assign fresh = eval_i ? found_i : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         code_o    <= '0;
         start_o   <= 1'b0;
         err_irq_o <= 1'b0;
      end else begin
         code_o    <= (clear_i ? '0 : code_o) | fresh;
         start_o   <= eval_i && (found_i == '0);
         err_irq_o <= eval_i && (found_i != '0);
      end
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(start_o && err_irq_o));  // R1
   AST_OUTCOME_FOLLOWS_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eval_i |=> (start_o || err_irq_o));  // R1
   AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eval_i |=> (!start_o && !err_irq_o));  // R1
   AST_IRQ_HAS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_irq_o |-> (code_o != '0));  // R12
   AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> ((code_o & $past(code_o)) == $past(code_o)));  // R12
   AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i && !eval_i) |=> (code_o == '0));  // R12
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
   import dcc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 32,
   parameter int OPC_W  = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               go_i,
   input  logic               err_clear_i,
   input  logic [ADDR_W-1:0]  src_addr_i,
   input  logic [ADDR_W-1:0]  dst_addr_i,
   input  logic [7:0]         space_id_i,
   input  logic [1:0]         width_code_i,
   input  logic [SIZE_W-1:0]  total_size_i,
   input  logic [SIZE_W-1:0]  chunk_size_i,
   input  logic [OPC_W-1:0]   opcode_i,
   input  logic [ADDR_W-1:0]  range_base_i,
   input  logic [ADDR_W-1:0]  range_limit_i,
   input  logic               range_valid_i,
   output logic [7:0]         err_code_o,
   output logic               start_o,
   output logic               err_irq_o
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (SIZE_W < 1) begin : g_bad_size
      $error("SIZE_W must be at least 1");
   end
   if (OPC_W < 2) begin : g_bad_opc
      $error("OPC_W must be at least 2");
   end

   logic               eval;
   logic [ADDR_W-1:0]  s_src, s_dst, s_base, s_limit;
   logic [7:0]         s_space;
   logic [1:0]         s_width;
   logic [SIZE_W-1:0]  s_total, s_chunk;
   logic [OPC_W-1:0]   s_opc;
   logic               s_valid;
   err_vec_t           found, code;

   dcc_snapshot #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OPC_W(OPC_W)) snap_i (
      .clk_i, .rst_ni, .go_i,
      .src_addr_i, .dst_addr_i, .space_id_i, .width_code_i,
      .total_size_i, .chunk_size_i, .opcode_i,
      .range_base_i, .range_limit_i, .range_valid_i,
      .eval_o        (eval),
      .src_addr_o    (s_src),
      .dst_addr_o    (s_dst),
      .space_id_o    (s_space),
      .width_code_o  (s_width),
      .total_size_o  (s_total),
      .chunk_size_o  (s_chunk),
      .opcode_o      (s_opc),
      .range_base_o  (s_base),
      .range_limit_o (s_limit),
      .range_valid_o (s_valid)
   );

   dcc_rules #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OPC_W(OPC_W)) rules_i (
      .src_addr_i    (s_src),
      .dst_addr_i    (s_dst),
      .space_id_i    (s_space),
      .width_code_i  (s_width),
      .total_size_i  (s_total),
      .chunk_size_i  (s_chunk),
      .opcode_i      (s_opc),
      .range_base_i  (s_base),
      .range_limit_i (s_limit),
      .range_valid_i (s_valid),
      .err_o         (found)
   );

   dcc_report report_i (
      .clk_i, .rst_ni,
      .eval_i    (eval),
      .found_i   (found),
      .clear_i   (err_clear_i),
      .code_o    (code),
      .start_o   (start_o),
      .err_irq_o (err_irq_o)
   );

   assign err_code_o = code;

   AST_GO_TO_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_i |=> eval);  // R1
   AST_START_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval && found == '0) |=> start_o);  // R1
endmodule

// File: tb/dma_cfg_checker_tb.sv
module dma_cfg_checker_tb_top;
   localparam int AW = 16;
   localparam int SW = 8;
   localparam int OW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go = 1'b0, clr = 1'b0;
   logic [AW-1:0] src, dst, base, limit;
   logic [7:0]    space;
   logic [1:0]    wcode;
   logic [SW-1:0] total, chunk;
   logic [OW-1:0] opc;
   logic          rvalid;
   logic [7:0]    code;
   logic          start, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dma_cfg_checker #(.ADDR_W(AW), .SIZE_W(SW), .OPC_W(OW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .go_i(go), .err_clear_i(clr),
      .src_addr_i(src), .dst_addr_i(dst), .space_id_i(space), .width_code_i(wcode),
      .total_size_i(total), .chunk_size_i(chunk), .opcode_i(opc),
      .range_base_i(base), .range_limit_i(limit), .range_valid_i(rvalid),
      .err_code_o(code), .start_o(start), .err_irq_o(irq)
   );

   // behavioural reference of the rule set
   function automatic int ref_rules(int s, int d, int sp, int w, int t, int c, int o,
                                    int b, int l, int v);
      int e = 0;
      int bytes = (w == 3) ? 1 : (1 << w);
      int sid = sp % 16;
      int did = sp / 16;
      bit sint = (sid == 7);
      bit dint = (did == 7);
      bit win  = (v != 0) && (b <= l);
      if (!(sid == 7 || sid == 10 || sid == 9) || !(did == 7 || did == 10 || did == 9))
         e += 128;
      if (w == 3 || t == 0 || c == 0 || (o >= 1 && o <= 3 && w != 2)) e += 8;
      if (o > 3) e += 4;
      if (v != 0 && b > l) e += 32;
      if ((sint || dint) && v == 0) e += 64;
      if ((s % bytes) != 0 || (s % 4) != (d % 4) || (sint && win && (s < b || s > l))) e += 1;
      if ((d % bytes) != 0 || (dint && win && (d < b || d > l))) e += 2;
      return e;
   endfunction

   int m_pend = 0, m_desc = 0, m_code = 0;
   bit m_start = 0, m_irq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend <= 0; m_code <= 0; m_start <= 0; m_irq <= 0;
      end else begin
         m_start <= (m_pend != 0) && (m_desc == 0);
         m_irq   <= (m_pend != 0) && (m_desc != 0);
         m_code  <= (clr ? 0 : m_code) | ((m_pend != 0) ? m_desc : 0);
         m_pend  <= go;
         if (go) m_desc <= ref_rules(src, dst, space, wcode, total, chunk, opc,
                                     base, limit, rvalid);
      end
   end

   function automatic string code_tag(int diff);
      if (diff & 8'h80) return "R2";
      if (diff & 8'h04) return "R6";
      if (diff & 8'h08) return "R3/R4/R5";
      if (diff & 8'h40) return "R9";
      if (diff & 8'h20) return "R10";
      if (diff & 8'h10) return "R12";
      return "R7/R8/R11";
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks += 3;
         if (int'(code) != m_code) begin
            errors++;
            $display("FAIL %s cycle code actual %h expected %h", code_tag(int'(code) ^ m_code),
                     code, m_code[7:0]);
         end
         if (start != m_start) begin
            errors++;
            $display("FAIL R1 cycle start actual %b expected %b", start, m_start);
         end
         if (irq != m_irq) begin
            errors++;
            $display("FAIL R1 cycle irq actual %b expected %b", irq, m_irq);
         end
      end
   end

   task automatic chk(string tag, logic [7:0] exp_code, logic exp_start, logic exp_irq);
      checks++;
      if (code !== exp_code || start !== exp_start || irq !== exp_irq) begin
         errors++;
         $display("FAIL %s actual code=%h start=%b irq=%b expected code=%h start=%b irq=%b",
                  tag, code, start, irq, exp_code, exp_start, exp_irq);
      end
   endtask

   task automatic legal_desc();
      src = 16'h0100; dst = 16'h0200; space = 8'h77; wcode = 2'd2;
      total = 8'd16; chunk = 8'd8; opc = 4'd0;
      base = 16'h0000; limit = 16'h0FFF; rvalid = 1'b1;
   endtask

   // clear, then launch one job and sample its outcome
   task automatic job(string tag, logic [7:0] exp_code);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      go = 1'b1; @(negedge clk); go = 1'b0; @(negedge clk);
      chk(tag, exp_code, exp_code == 8'h00, exp_code != 8'h00);
   endtask

   initial begin
      #(4 * 20000);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      legal_desc();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 reset", 8'h00, 1'b0, 1'b0);

      job("R1 legal copy", 8'h00);
      legal_desc(); space = 8'h73; job("R2 bad src id", 8'h80);
      legal_desc(); space = 8'h37; job("R2 bad dst id", 8'h80);
      legal_desc(); space = 8'h9A; rvalid = 1'b0; job("R2 R9 legal non-internal ids", 8'h00);
      legal_desc(); wcode = 2'd3; job("R3 width code 3", 8'h08);
      legal_desc(); total = 8'd0; job("R4 zero total", 8'h08);
      legal_desc(); chunk = 8'd0; job("R4 zero chunk", 8'h08);
      legal_desc(); opc = 4'd2; job("R5 hash at 4 bytes", 8'h00);
      legal_desc(); opc = 4'd1; wcode = 2'd1; job("R5 hash at 2 bytes", 8'h08);
      legal_desc(); wcode = 2'd0; job("R5 copy at 1 byte", 8'h00);
      legal_desc(); opc = 4'd5; job("R6 opcode 5", 8'h04);
      legal_desc(); src = 16'h0102; dst = 16'h0202; job("R7 word misalign", 8'h03);
      legal_desc(); src = 16'h0102; dst = 16'h0202; wcode = 2'd1; job("R7 half aligned", 8'h00);
      legal_desc(); src = 16'h0101; dst = 16'h0203; wcode = 2'd0; job("R8 mismatch", 8'h01);
      legal_desc(); rvalid = 1'b0; job("R9 no window", 8'h40);
      legal_desc(); space = 8'h79; rvalid = 1'b0; job("R9 dst internal", 8'h40);
      legal_desc(); base = 16'h2000; limit = 16'h1000; job("R10 inverted window", 8'h20);
      legal_desc(); base = 16'h0100; limit = 16'h01FF; job("R11 dst past limit", 8'h02);
      legal_desc(); base = 16'h0100; limit = 16'h01FF; src = 16'h00FC; dst = 16'h01FC;
      job("R11 src below base", 8'h01);
      legal_desc(); base = 16'h0100; limit = 16'h01FF; space = 8'h97; job("R11 dst system bus", 8'h00);

      // R12 sticky accumulation, clear, clear coinciding with evaluation
      legal_desc(); opc = 4'd5; job("R12 first job", 8'h04);
      legal_desc(); space = 8'h7F;
      go = 1'b1; @(negedge clk); go = 1'b0; @(negedge clk);
      chk("R12 accumulate", 8'h84, 1'b0, 1'b1);
      legal_desc(); wcode = 2'd3;
      go = 1'b1; @(negedge clk); go = 1'b0; clr = 1'b1; @(negedge clk); clr = 1'b0;
      chk("R12 clear with eval", 8'h08, 1'b0, 1'b1);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      chk("R12 clear", 8'h00, 1'b0, 1'b0);

      // R13 descriptor changes without go
      opc = 4'd9; space = 8'h00; total = 8'd0;
      repeat (4) @(negedge clk);
      chk("R13 no go", 8'h00, 1'b0, 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule